// File: doc/BRIEF.md
# In-Order Retirement Buffer with Precise Faults

This block holds every in-flight instruction from dispatch until retirement. Each slot carries a tag-or-value field for each of two source operands with a ready flag, a result value with a done flag, the destination register, an issued flag and a fault flag. The slot index is the tag that the execution side uses when it returns a result. Results arrive on a single result bus in any order. The bus also wakes up any source operand that is waiting on that tag. The oldest waiting slot whose operands are all ready is offered for issue.

Retirement is strictly in order. The oldest slot may only leave once its result is done. A clean result is written into a separate architectural register file. A faulting result instead raises a fault report that carries the slot index, and every slot is discarded, so the architectural file holds exactly the state from before the faulting instruction. A dispatching instruction finds each source in one of two places. The first is the youngest in-flight slot that writes that register, if there is one. Otherwise the source comes from the architectural file.

The execution units and the instruction supply are outside the block. The block presents an issue offer, accepts results, and reports retirements and faults one cycle after they happen.

Top module: `rob_core`

## Requirements
- R1: After a synchronous reset the buffer is empty: disp_ready is 1, iss_valid, cmt_valid and exc_valid are 0, and every architectural register reads 0.
- R2: disp_tag is the slot index a dispatch receives. Successive accepted dispatches receive consecutive indices modulo DEPTH. After a fault, numbering resumes at the faulting slot's index.
- R3: disp_ready is 0 while DEPTH instructions are held and during the cycle a fault is taken. A disp_valid presented while disp_ready is 0 is dropped and consumes no slot.
- R4: Retirements appear in dispatch order, at most one per cycle. cmt_valid, cmt_rd and cmt_data are presented in the cycle after the oldest slot becomes done.
- R5: While the oldest slot is not done, nothing retires, even if younger slots are done.
- R6: The architectural file changes only on retirement. dbg_rdata returns the register named by dbg_raddr one cycle later.
- R7: A source operand takes its value from the youngest older in-flight writer of that register. If that writer is done, the value is taken directly. If not, the operand waits on the writer's tag. If there is no in-flight writer, the value comes from the architectural file.
- R8: A result-bus write to tag T marks slot T done and fills every operand waiting on T. A write in the same cycle as a dispatch that depends on T counts as ready for that dispatch. iss_valid offers the oldest unissued slot with both operands ready, with their values on iss_op1 and iss_op2.
- R9: When the oldest slot is done with wb_xcpt set, exc_valid pulses one cycle later with exc_tag equal to that slot's index. That slot and all younger ones are discarded, none of them reaches the architectural file, and the buffer is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_rs1 | input | $clog2(NREG) | First source register |
| disp_rs2 | input | $clog2(NREG) | Second source register |
| disp_rd | input | $clog2(NREG) | Destination register |
| disp_ready | output | 1 | A dispatch is accepted this cycle |
| disp_tag | output | $clog2(DEPTH) | Slot index given to the dispatch |
| iss_valid | output | 1 | A slot is offered for execution |
| iss_ready | input | 1 | Execution side accepts the offer |
| iss_tag | output | $clog2(DEPTH) | Offered slot index |
| iss_op1 | output | XLEN | First operand value |
| iss_op2 | output | XLEN | Second operand value |
| wb_valid | input | 1 | Result bus write |
| wb_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| wb_data | input | XLEN | Result value |
| wb_xcpt | input | 1 | Result carries a fault |
| cmt_valid | output | 1 | A slot retired in the previous cycle |
| cmt_rd | output | $clog2(NREG) | Register written by that retirement |
| cmt_data | output | XLEN | Value written by that retirement |
| exc_valid | output | 1 | A fault was taken in the previous cycle |
| exc_tag | output | $clog2(DEPTH) | Index of the faulting slot |
| dbg_raddr | input | $clog2(NREG) | Architectural register to read back |
| dbg_rdata | output | XLEN | Registered read-back value |

## Verification
The result-bus assertion assumes that the execution side writes each result once, only to a slot that is live and already issued, and never to a slot that is already done. The bench acts as the execution unit and tracks which tags it has accepted from the issue offer. It returns results only for those tags, in newest-first order, and drops its pending list as soon as a fault is reported. The bench never drives a result in the same cycle as the issue that produced it. Dispatches respect disp_ready, except for one deliberate attempt on a full buffer, which checks that the instruction is dropped.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Condition of the oldest slot, which decides retirement each cycle.
  typedef enum logic [1:0] {
    HEAD_IDLE   = 2'd0,  // nothing held
    HEAD_BUSY   = 2'd1,  // oldest slot still waiting for its result
    HEAD_RETIRE = 2'd2,  // oldest slot done and clean
    HEAD_FAULT  = 2'd3   // oldest slot done with a fault
  } head_state_e;

endpackage

// File: rtl/rob_arf.sv
module rob_arf #(
  parameter int NREG = 8,
  parameter int XLEN = 16,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RW-1:0]   ra1,
  output logic [XLEN-1:0] rd1,
  input  logic [RW-1:0]   ra2,
  output logic [XLEN-1:0] rd2,
  input  logic [RW-1:0]   ra3,
  output logic [XLEN-1:0] rd3
);

  logic [XLEN-1:0] regs [NREG];

  // Distributed-memory style: a small file with a reset to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  always_ff @(posedge clk) begin
    if (rst) rd3 <= '0;
    else     rd3 <= regs[ra3];
  end

endmodule

// File: rtl/rob_src_lookup.sv
module rob_src_lookup #(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  parameter int XLEN  = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int RW    = $clog2(NREG)
) (
  input  logic [IW-1:0]                oldest,
  input  logic [DEPTH-1:0]             live,
  input  logic [DEPTH-1:0][RW-1:0]     ent_rd,
  input  logic [DEPTH-1:0]             ent_done,
  input  logic [DEPTH-1:0][XLEN-1:0]   ent_res,
  input  logic [RW-1:0]                query,
  input  logic [XLEN-1:0]              arf_val,
  input  logic                         bus_valid,
  input  logic [IW-1:0]                bus_tag,
  input  logic [XLEN-1:0]              bus_data,
  output logic                         ready,
  output logic [XLEN-1:0]              field
);

  logic          hit;
  logic [IW-1:0] prod;
  logic [IW-1:0] idx;

  // Walk from oldest to newest; the last match is the youngest writer.
  always_comb begin
    hit  = 1'b0;
    prod = '0;
    idx  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = oldest + IW'(k);
      if (live[idx] && ent_rd[idx] == query) begin
        hit  = 1'b1;
        prod = idx;
      end
    end
  end

  always_comb begin
    if (!hit) begin
      ready = 1'b1;
      field = arf_val;
    end else if (ent_done[prod]) begin
      ready = 1'b1;
      field = ent_res[prod];
    end else if (bus_valid && bus_tag == prod) begin
      ready = 1'b1;
      field = bus_data;
    end else begin
      ready = 1'b0;
      field = {{(XLEN-IW){1'b0}}, prod};
    end
  end

endmodule

// File: rtl/rob_issue_sel.sv
module rob_issue_sel #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    oldest,
  input  logic [DEPTH-1:0] live,
  input  logic [DEPTH-1:0] issued,
  input  logic [DEPTH-1:0] op1_ok,
  input  logic [DEPTH-1:0] op2_ok,
  output logic             pick_valid,
  output logic [IW-1:0]    pick_idx
);

  logic [IW-1:0] idx;

  // Age order starts at the oldest slot; the first candidate wins.
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    idx        = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = oldest + IW'(k);
      if (!pick_valid && live[idx] && !issued[idx] && op1_ok[idx] && op2_ok[idx]) begin
        pick_valid = 1'b1;
        pick_idx   = idx;
      end
    end
  end

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  parameter int XLEN  = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            disp_valid,
  input  logic [RW-1:0]   disp_rs1,
  input  logic [RW-1:0]   disp_rs2,
  input  logic [RW-1:0]   disp_rd,
  output logic            disp_ready,
  output logic [IW-1:0]   disp_tag,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [IW-1:0]   iss_tag,
  output logic [XLEN-1:0] iss_op1,
  output logic [XLEN-1:0] iss_op2,
  input  logic            wb_valid,
  input  logic [IW-1:0]   wb_tag,
  input  logic [XLEN-1:0] wb_data,
  input  logic            wb_xcpt,
  output logic            cmt_valid,
  output logic [RW-1:0]   cmt_rd,
  output logic [XLEN-1:0] cmt_data,
  output logic            exc_valid,
  output logic [IW-1:0]   exc_tag,
  input  logic [RW-1:0]   dbg_raddr,
  output logic [XLEN-1:0] dbg_rdata
);

  localparam int PW = IW + 1;

  // Pointers with a wrap bit above the slot index.
  logic [PW-1:0] head_q, tail_q;
  logic [IW-1:0] hidx, tidx;
  logic          empty, full;

  // Per-slot state.
  logic [DEPTH-1:0]           v_q, iss_q, s1p_q, s2p_q, rp_q, x_q;
  logic [DEPTH-1:0][XLEN-1:0] s1_q, s2_q, rv_q;
  logic [DEPTH-1:0][RW-1:0]   rd_q;

  head_state_e hstate;
  logic        do_commit, do_flush, disp_fire, iss_fire;

  logic [XLEN-1:0] arf1, arf2;
  logic            src1_ok, src2_ok;
  logic [XLEN-1:0] src1_f, src2_f;

  assign hidx  = head_q[IW-1:0];
  assign tidx  = tail_q[IW-1:0];
  assign empty = (head_q == tail_q);
  assign full  = (hidx == tidx) && (head_q[IW] != tail_q[IW]);

  always_comb begin
    if (empty)            hstate = HEAD_IDLE;
    else if (!rp_q[hidx]) hstate = HEAD_BUSY;
    else if (x_q[hidx])   hstate = HEAD_FAULT;
    else                  hstate = HEAD_RETIRE;
  end

  assign do_commit  = (hstate == HEAD_RETIRE);
  assign do_flush   = (hstate == HEAD_FAULT);
  assign disp_ready = !full && !do_flush;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_tag   = tidx;

  rob_arf #(.NREG(NREG), .XLEN(XLEN), .RW(RW)) u_arf (
    .clk   (clk),
    .rst   (rst),
    .we    (do_commit),
    .waddr (rd_q[hidx]),
    .wdata (rv_q[hidx]),
    .ra1   (disp_rs1),
    .rd1   (arf1),
    .ra2   (disp_rs2),
    .rd2   (arf2),
    .ra3   (dbg_raddr),
    .rd3   (dbg_rdata)
  );

  rob_src_lookup #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .IW(IW), .RW(RW)) u_look1 (
    .oldest    (hidx),
    .live      (v_q),
    .ent_rd    (rd_q),
    .ent_done  (rp_q),
    .ent_res   (rv_q),
    .query     (disp_rs1),
    .arf_val   (arf1),
    .bus_valid (wb_valid),
    .bus_tag   (wb_tag),
    .bus_data  (wb_data),
    .ready     (src1_ok),
    .field     (src1_f)
  );

  rob_src_lookup #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .IW(IW), .RW(RW)) u_look2 (
    .oldest    (hidx),
    .live      (v_q),
    .ent_rd    (rd_q),
    .ent_done  (rp_q),
    .ent_res   (rv_q),
    .query     (disp_rs2),
    .arf_val   (arf2),
    .bus_valid (wb_valid),
    .bus_tag   (wb_tag),
    .bus_data  (wb_data),
    .ready     (src2_ok),
    .field     (src2_f)
  );

  rob_issue_sel #(.DEPTH(DEPTH), .IW(IW)) u_sel (
    .oldest     (hidx),
    .live       (v_q),
    .issued     (iss_q),
    .op1_ok     (s1p_q),
    .op2_ok     (s2p_q),
    .pick_valid (iss_valid),
    .pick_idx   (iss_tag)
  );

  assign iss_op1  = s1_q[iss_tag];
  assign iss_op2  = s2_q[iss_tag];
  assign iss_fire = iss_valid && iss_ready;

  // Control state: pointers, live and issued flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      v_q    <= '0;
      iss_q  <= '0;
    end else if (do_flush) begin
      v_q    <= '0;
      tail_q <= head_q;
    end else begin
      if (do_commit) begin
        head_q    <= head_q + 1'b1;
        v_q[hidx] <= 1'b0;
      end
      if (disp_fire) begin
        tail_q      <= tail_q + 1'b1;
        v_q[tidx]   <= 1'b1;
        iss_q[tidx] <= 1'b0;
      end
      if (iss_fire) iss_q[iss_tag] <= 1'b1;
    end
  end

  // Payload: written at dispatch, updated by the result bus.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (disp_fire && tidx == IW'(i)) begin
        s1p_q[i] <= src1_ok;
        s1_q[i]  <= src1_f;
        s2p_q[i] <= src2_ok;
        s2_q[i]  <= src2_f;
        rp_q[i]  <= 1'b0;
        rv_q[i]  <= '0;
        x_q[i]   <= 1'b0;
        rd_q[i]  <= disp_rd;
      end else if (v_q[i] && wb_valid) begin
        if (wb_tag == IW'(i)) begin
          rp_q[i] <= 1'b1;
          rv_q[i] <= wb_data;
          x_q[i]  <= wb_xcpt;
        end
        if (!s1p_q[i] && s1_q[i][IW-1:0] == wb_tag) begin
          s1p_q[i] <= 1'b1;
          s1_q[i]  <= wb_data;
        end
        if (!s2p_q[i] && s2_q[i][IW-1:0] == wb_tag) begin
          s2p_q[i] <= 1'b1;
          s2_q[i]  <= wb_data;
        end
      end
    end
  end

  // Registered retirement and fault reports.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid <= 1'b0;
      cmt_rd    <= '0;
      cmt_data  <= '0;
      exc_valid <= 1'b0;
      exc_tag   <= '0;
    end else begin
      cmt_valid <= do_commit;
      cmt_rd    <= rd_q[hidx];
      cmt_data  <= rv_q[hidx];
      exc_valid <= do_flush;
      exc_tag   <= hidx;
    end
  end

  // Occupancy never exceeds the slot count.
  logic [PW-1:0] occ;
  assign occ = tail_q - head_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= PW'(DEPTH));

  // Results only go to live, issued, not-yet-done slots (input contract).
  p_wb_live_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (v_q[wb_tag] && iss_q[wb_tag] && !rp_q[wb_tag]));

  // A reported fault leaves the buffer empty.
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (head_q == tail_q));

  // The reported slot is the oldest one, which stays put across a fault.
  p_exc_at_head_r9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_tag == hidx));

  // Retirement and fault never coincide.
  p_single_event_r4: assert property (@(posedge clk) disable iff (rst)
    !(cmt_valid && exc_valid));

endmodule

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;

  localparam int DEPTH = 8;
  localparam int NREG  = 8;
  localparam int XLEN  = 16;
  localparam int IW    = $clog2(DEPTH);
  localparam int RW    = $clog2(NREG);

  // Vector: {rs1[9:7], rs2[6:4], rd[3:1], fault[0]}; result = op1 + op2 + 1
  localparam logic [9:0] VEC [8] = '{
    {3'd0, 3'd0, 3'd1, 1'b0},
    {3'd1, 3'd1, 3'd2, 1'b0},
    {3'd2, 3'd0, 3'd3, 1'b0},
    {3'd3, 3'd2, 3'd1, 1'b0},
    {3'd1, 3'd1, 3'd4, 1'b0},
    {3'd4, 3'd3, 3'd5, 1'b1},
    {3'd5, 3'd5, 3'd6, 1'b0},
    {3'd6, 3'd1, 3'd7, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            disp_valid = 1'b0;
  logic [RW-1:0]   disp_rs1 = '0, disp_rs2 = '0, disp_rd = '0;
  logic            disp_ready;
  logic [IW-1:0]   disp_tag;
  logic            iss_valid;
  logic            iss_ready = 1'b0;
  logic [IW-1:0]   iss_tag;
  logic [XLEN-1:0] iss_op1, iss_op2;
  logic            wb_valid = 1'b0;
  logic [IW-1:0]   wb_tag = '0;
  logic [XLEN-1:0] wb_data = '0;
  logic            wb_xcpt = 1'b0;
  logic            cmt_valid;
  logic [RW-1:0]   cmt_rd;
  logic [XLEN-1:0] cmt_data;
  logic            exc_valid;
  logic [IW-1:0]   exc_tag;
  logic [RW-1:0]   dbg_raddr = '0;
  logic [XLEN-1:0] dbg_rdata;

  always #2.5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) u_dut (.*);

  int n_cmp = 0, n_bad = 0, commits = 0, faults = 0;

  // Reference model
  logic [XLEN-1:0] arch_ref [NREG];
  logic [XLEN-1:0] prog_val [NREG];
  logic [XLEN-1:0] exp_op1 [DEPTH], exp_op2 [DEPTH], exp_res [DEPTH];
  logic [RW-1:0]   exp_rd [DEPTH];
  logic            exp_fault [DEPTH];
  logic [IW-1:0]   q [64];
  int              q_rd = 0, q_wr = 0, q_cnt = 0;
  logic [IW-1:0]   pend [DEPTH];
  int              pend_cnt = 0;
  logic [IW-1:0]   exp_tail = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon();
    logic [IW-1:0] t;
    if (cmt_valid) begin
      if (q_cnt == 0) chk(0, "R4", "retirement with nothing pending", cmt_rd, 0);
      else begin
        t = q[q_rd];
        chk(cmt_rd == exp_rd[t], "R4", "retired register", cmt_rd, exp_rd[t]);
        chk(cmt_data == exp_res[t], "R4", "retired value", cmt_data, exp_res[t]);
        arch_ref[exp_rd[t]] = exp_res[t];
        q_rd = (q_rd + 1) % 64;
        q_cnt--;
        commits++;
      end
    end
    if (exc_valid) begin
      if (q_cnt == 0) chk(0, "R9", "fault with nothing pending", exc_tag, 0);
      else begin
        chk(exc_tag == q[q_rd], "R9", "fault index", exc_tag, q[q_rd]);
        chk(exp_fault[q[q_rd]] == 1'b1, "R9", "fault on clean slot", 0, 1);
      end
      q_cnt = 0;
      q_rd = q_wr;
      pend_cnt = 0;
      for (int r = 0; r < NREG; r++) prog_val[r] = arch_ref[r];
      exp_tail = exc_tag;
      faults++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    disp_valid = 1'b0;
    iss_ready  = 1'b0;
    wb_valid   = 1'b0;
    wb_xcpt    = 1'b0;
    @(negedge clk);
    mon();
  endtask

  task automatic dispatch(input logic [RW-1:0] s1, input logic [RW-1:0] s2,
                          input logic [RW-1:0] d, input logic f,
                          output logic [IW-1:0] tag);
    disp_valid = 1'b1;
    disp_rs1 = s1;
    disp_rs2 = s2;
    disp_rd = d;
    #0.1;
    chk(disp_ready == 1'b1, "R3", "ready with free slot", disp_ready, 1);
    chk(disp_tag == exp_tail, "R2", "slot index", disp_tag, exp_tail);
    tag = disp_tag;
    exp_op1[tag] = prog_val[s1];
    exp_op2[tag] = prog_val[s2];
    exp_res[tag] = prog_val[s1] + prog_val[s2] + 16'd1;
    exp_rd[tag] = d;
    exp_fault[tag] = f;
    prog_val[d] = exp_res[tag];
    q[q_wr] = tag;
    q_wr = (q_wr + 1) % 64;
    q_cnt++;
    exp_tail = exp_tail + 1'b1;
    tick();
  endtask

  task automatic accept_issue();
    iss_ready = 1'b1;
    chk(iss_op1 == exp_op1[iss_tag], "R7", "first operand", iss_op1, exp_op1[iss_tag]);
    chk(iss_op2 == exp_op2[iss_tag], "R8", "second operand", iss_op2, exp_op2[iss_tag]);
  endtask

  task automatic drive_wb(input logic [IW-1:0] t);
    wb_valid = 1'b1;
    wb_tag = t;
    wb_data = exp_res[t];
    wb_xcpt = exp_fault[t];
  endtask

  task automatic drain(input int maxc);
    for (int c = 0; c < maxc && (q_cnt != 0 || pend_cnt != 0); c++) begin
      if (pend_cnt > 0) begin
        pend_cnt--;
        drive_wb(pend[pend_cnt]);
      end
      if (iss_valid) begin
        accept_issue();
        pend[pend_cnt] = iss_tag;
        pend_cnt++;
      end
      tick();
    end
    chk(q_cnt == 0, "R8", "work left after drain", q_cnt, 0);
  endtask

  task automatic read_arf(input logic [RW-1:0] r, output logic [XLEN-1:0] v);
    dbg_raddr = r;
    tick();
    v = dbg_rdata;
  endtask

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [IW-1:0]   t, ta, tc, td;
    logic [XLEN-1:0] v;
    int              base;
    for (int r = 0; r < NREG; r++) begin
      arch_ref[r] = '0;
      prog_val[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(disp_ready == 1'b1, "R1", "disp_ready after reset", disp_ready, 1);
    chk(iss_valid == 1'b0, "R1", "iss_valid after reset", iss_valid, 0);
    chk(cmt_valid == 1'b0, "R1", "cmt_valid after reset", cmt_valid, 0);
    chk(exc_valid == 1'b0, "R1", "exc_valid after reset", exc_valid, 0);
    for (int r = 0; r < NREG; r++) begin
      read_arf(RW'(r), v);
      chk(v == '0, "R1", "register after reset", v, 0);
    end

    // Table walk: fill all slots, one faulting entry
    for (int i = 0; i < 8; i++) begin
      dispatch(VEC[i][9:7], VEC[i][6:4], VEC[i][3:1], VEC[i][0], t);
    end
    chk(disp_ready == 1'b0, "R3", "ready when full", disp_ready, 0);
    drain(200);
    chk(faults == 1, "R9", "fault count", faults, 1);
    chk(commits == 5, "R9", "retirements before fault", commits, 5);
    for (int r = 0; r < NREG; r++) begin
      read_arf(RW'(r), v);
      chk(v == arch_ref[r], "R9", "register after fault", v, arch_ref[r]);
    end

    // R5: younger done first, oldest holds everything back
    dispatch(3'd1, 3'd2, 3'd6, 1'b0, t);
    dispatch(3'd3, 3'd0, 3'd7, 1'b0, t);
    dispatch(3'd4, 3'd4, 3'd5, 1'b0, t);
    for (int i = 0; i < 3; i++) begin
      chk(iss_valid && iss_tag == IW'(5 + i), "R8", "oldest-first issue", iss_tag, 5 + i);
      accept_issue();
      tick();
    end
    drive_wb(3'd6);
    tick();
    drive_wb(3'd7);
    tick();
    base = commits;
    for (int i = 0; i < 3; i++) begin
      read_arf(3'd7, v);
      chk(cmt_valid == 1'b0, "R5", "no retirement behind busy oldest", cmt_valid, 0);
      chk(v == arch_ref[7], "R6", "register untouched before retirement", v, arch_ref[7]);
    end
    drive_wb(3'd5);
    tick();
    chk(cmt_valid == 1'b0, "R4", "retirement one cycle late", cmt_valid, 0);
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk(commits == base + i, "R4", "one retirement per cycle", commits - base, i);
    end
    read_arf(3'd7, v);
    chk(v == arch_ref[7], "R6", "register after retirement", v, arch_ref[7]);

    // R3: full buffer drops an extra dispatch
    for (int i = 0; i < DEPTH; i++) begin
      dispatch(RW'(i), RW'(i + 1), RW'(i + 3), 1'b0, t);
    end
    chk(disp_ready == 1'b0, "R3", "ready when full", disp_ready, 0);
    disp_valid = 1'b1;
    disp_rs1 = 3'd0;
    disp_rs2 = 3'd0;
    disp_rd = 3'd0;
    tick();
    base = commits;
    drain(200);
    chk(commits == base + DEPTH, "R3", "retirements from full buffer", commits - base, DEPTH);
    dispatch(3'd2, 3'd3, 3'd0, 1'b0, t);
    chk(t == '0, "R3", "dropped dispatch took no slot", t, 0);
    drain(100);

    // R8: same-cycle result bypass into a dispatch
    dispatch(3'd1, 3'd1, 3'd2, 1'b0, ta);
    chk(iss_valid && iss_tag == ta, "R8", "producer offered", iss_tag, ta);
    accept_issue();
    tick();
    drive_wb(ta);
    dispatch(3'd2, 3'd0, 3'd3, 1'b0, t);
    drain(50);

    // R7: one source from a done in-flight writer, one waiting on a tag
    dispatch(3'd1, 3'd2, 3'd4, 1'b0, tc);
    dispatch(3'd0, 3'd0, 3'd5, 1'b0, td);
    accept_issue();
    tick();
    accept_issue();
    tick();
    drive_wb(td);
    tick();
    dispatch(3'd5, 3'd4, 3'd6, 1'b0, t);
    chk(iss_valid == 1'b0, "R7", "consumer waits on busy writer", iss_valid, 0);
    pend[0] = tc;
    pend_cnt = 1;
    drain(50);

    for (int r = 0; r < NREG; r++) begin
      read_arf(RW'(r), v);
      chk(v == arch_ref[r], "R6", "final register", v, arch_ref[r]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule